// File: doc/BRIEF.md
# ADC Conversion-Group DMA Request Generator

This block decides when a single ADC conversion group should ask a DMA engine to move results out of its result memory. It watches two strobes from the group: one fires when a result is written into the result memory, and the other fires when the group has converted every selected channel. From these it issues a one-clock DMA request. Software picks one of three request policies through a memory-mapped control register: a request for every result, a request for every N results, or a request for every completed group.

The every-N policy uses a down-counting threshold counter. The counter is loaded from a 9-bit block-count field. Each result write steps it down by one, and a request is raised on the step from 1 to 0, in the same cycle that the counter reloads. When the completion policy is enabled it takes priority over both other policies. When either mode bit is set, the per-result enable is ignored. The completion-mode bit should be programmed before the group's conversions are started. The request is registered, so it appears one cycle after the triggering strobe.

Top module: `adc_dma_req_gen`

## Requirements
- R1: After reset, `dma_req` is 0 and the control register reads 0x00000000.
- R2: The control register is at offset 0x4C. It has these fields: block count at bits 24:16, completion-mode enable at bit 3, block-mode enable at bit 2, and per-result enable at bit 0. All other bits read 0 and ignore writes, so writing 0xFFFFFFFF reads back 0x01FF000D.
- R3: A read of any other offset returns 0. A write to any other offset leaves the control register unchanged.
- R4: When bit 0 is 1 and bits 3 and 2 are 0, each `res_wr` pulse produces `dma_req` high in the following cycle. When bit 0 is 0 and both mode bits are 0, `res_wr` produces no request.
- R5: When bit 2 is 1 and bit 3 is 0, a request is raised one cycle after the N-th `res_wr` since the last load or reload, where N is the block count (1 to 511). After that it repeats every N writes, whatever the value of bit 0.
- R6: When bit 2 is 1 and the block count is 0, no request is ever raised.
- R7: When bit 3 is 1, each `grp_done` pulse produces `dma_req` in the following cycle, and `res_wr` produces no request, whatever the value of bit 0.
- R8: When bits 3 and 2 are both 1, only `grp_done` produces requests.
- R9: Any write to the control register loads the threshold counter with the written block count. This load overrides a decrement in the same cycle. The request decision for that cycle uses the settings that were in force before the write.
- R10: Each request is exactly one cycle for each triggering event. `grp_done` has no effect unless bit 3 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| res_wr | input | 1 | Result written into the group's result memory |
| grp_done | input | 1 | Group finished converting all selected channels |
| dma_req | output | 1 | One-cycle DMA request |

## Verification
Two functions can fall in the same cycle: a control-register write (counter load) and a result write (counter decrement and threshold decision). The random phase drives writes and result strobes on independent random draws, so they regularly coincide. A directed case also writes a new block count in the very cycle that the counter steps from 1 to 0. The bench judges such a cycle by two rules: the request follows the settings from before the write, and the counter continues from the newly written count. It checks the request timing over the following writes and the read-back of the register.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;
  localparam int DATA_W    = 32;
  localparam int CNT_W     = 9;
  localparam int COUNT_LSB = 16;
  localparam int EOC_BIT   = 3;
  localparam int BLK_BIT   = 2;
  localparam int PW_BIT    = 0;

  typedef struct packed {
    logic [CNT_W-1:0] count;
    logic             eoc_en;
    logic             blk_en;
    logic             pw_en;
  } dma_cfg_t;

  // Extract the live fields from a bus word; reserved bits are dropped.
  function automatic dma_cfg_t ctrl_unpack(input logic [DATA_W-1:0] w);
    dma_cfg_t c;
    c.count  = w[COUNT_LSB +: CNT_W];
    c.eoc_en = w[EOC_BIT];
    c.blk_en = w[BLK_BIT];
    c.pw_en  = w[PW_BIT];
    return c;
  endfunction

  // Build the read image; reserved bits are zero.
  function automatic logic [DATA_W-1:0] ctrl_pack(input dma_cfg_t c);
    logic [DATA_W-1:0] r;
    r = '0;
    r[COUNT_LSB +: CNT_W] = c.count;
    r[EOC_BIT] = c.eoc_en;
    r[BLK_BIT] = c.blk_en;
    r[PW_BIT]  = c.pw_en;
    return r;
  endfunction

  // Threshold counter next state: load wins, a step from 1 reloads.
  function automatic logic [CNT_W-1:0] thr_next(
      input logic [CNT_W-1:0] cur,
      input logic [CNT_W-1:0] reload,
      input logic             load,
      input logic [CNT_W-1:0] load_val,
      input logic             dec);
    if (load)
      return load_val;
    if (dec && (cur != '0))
      return (cur == CNT_W'(1)) ? reload : cur - CNT_W'(1);
    return cur;
  endfunction
endpackage

// File: rtl/adc_dma_cfg_reg.sv
module adc_dma_cfg_reg
  import adc_dma_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(8'h4C)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output dma_cfg_t          cfg,
  output logic              cfg_wr,
  output logic [CNT_W-1:0]  cfg_wr_count
);
  logic     hit;
  dma_cfg_t wr_cfg;

  assign hit          = (bus_addr == CTRL_ADDR);
  assign cfg_wr       = hit && bus_we;
  assign wr_cfg       = ctrl_unpack(bus_wdata);
  assign cfg_wr_count = wr_cfg.count;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg <= '0;
    else if (cfg_wr) cfg <= wr_cfg;
  end

  assign bus_rdata = hit ? ctrl_pack(cfg) : '0;

  // R3: a write elsewhere never changes the register
  a_r3_other_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !hit) |=> $stable(cfg));
  // R2: written fields land in the register
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg.count == $past(bus_wdata[COUNT_LSB +: CNT_W])));
endmodule

// File: rtl/adc_dma_thr_cnt.sv
module adc_dma_thr_cnt
  import adc_dma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  dma_cfg_t         cfg,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_wr_count,
  input  logic             res_wr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             thr_hit
);
  logic dec;

  assign dec     = cfg.blk_en && res_wr;
  assign thr_hit = dec && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= thr_next(cnt_q, cfg.count, cfg_wr, cfg_wr_count, dec);
  end

  // R9: a register write loads the written count, overriding a decrement
  a_r9_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cnt_q == $past(cfg_wr_count)));
  // R5: counter never exceeds the programmed count
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= cfg.count);
  // R6: a zero count keeps the counter at zero
  a_r6_zero_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !cfg_wr) |=> (cnt_q == '0));
endmodule

// File: rtl/adc_dma_req_sel.sv
module adc_dma_req_sel
  import adc_dma_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  dma_cfg_t cfg,
  input  logic     res_wr,
  input  logic     grp_done,
  input  logic     thr_hit,
  output logic     dma_req
);
  logic eoc_fire, blk_fire, pw_fire, fire;

  // Priority: completion mode, then block mode, then per-result.
  assign eoc_fire = cfg.eoc_en && grp_done;
  assign blk_fire = !cfg.eoc_en && cfg.blk_en && thr_hit;
  assign pw_fire  = !cfg.eoc_en && !cfg.blk_en && cfg.pw_en && res_wr;
  assign fire     = eoc_fire || blk_fire || pw_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) dma_req <= 1'b0;
    else        dma_req <= fire;
  end

  // R4: per-result mode answers every result write
  a_r4_per_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.pw_en && !cfg.blk_en && !cfg.eoc_en && res_wr) |=> dma_req);
  // R7: completion mode answers every group end
  a_r7_group_end: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.eoc_en && grp_done) |=> dma_req);
  // R8: completion mode silences all other sources
  a_r8_eoc_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.eoc_en && !grp_done) |=> !dma_req);
  // R10: no request without an event in the cycle before
  a_r10_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_wr && !grp_done) |=> !dma_req);
endmodule

// File: rtl/adc_dma_req_gen.sv
module adc_dma_req_gen
  import adc_dma_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(8'h4C)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              res_wr,
  input  logic              grp_done,
  output logic              dma_req
);
  dma_cfg_t         cfg;
  logic             cfg_wr;
  logic [CNT_W-1:0] cfg_wr_count;
  logic [CNT_W-1:0] cnt_q;
  logic             thr_hit;

  adc_dma_cfg_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_cfg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg(cfg),
    .cfg_wr(cfg_wr), .cfg_wr_count(cfg_wr_count));

  adc_dma_thr_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .cfg_wr(cfg_wr),
    .cfg_wr_count(cfg_wr_count), .res_wr(res_wr), .cnt_q(cnt_q),
    .thr_hit(thr_hit));

  adc_dma_req_sel u_sel (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .res_wr(res_wr),
    .grp_done(grp_done), .thr_hit(thr_hit), .dma_req(dma_req));

  // R5: a threshold hit only happens in block mode on a result write
  a_r5_hit_source: assert property (@(posedge clk) disable iff (!rst_n)
    thr_hit |-> (cfg.blk_en && res_wr && cnt_q != '0));
endmodule

// File: tb/adc_dma_req_gen_test.sv
`timescale 1ns/100ps
module adc_dma_req_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h4C;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        res_wr = 1'b0;
  logic        grp_done = 1'b0;
  logic        dma_req;

  always #2.5 clk = ~clk;

  adc_dma_req_gen uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .res_wr(res_wr),
    .grp_done(grp_done), .dma_req(dma_req));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench model of the register and counter
  int m_count = 0;
  int m_cnt   = 0;
  bit m_eoc = 0, m_blk = 0, m_pw = 0;

  function automatic logic [31:0] model_image(input logic [7:0] a);
    if (a != 8'h4C) return 32'h0;
    return (32'(m_count) * 65536) + (m_eoc ? 32'd8 : 32'd0) +
           (m_blk ? 32'd4 : 32'd0) + (m_pw ? 32'd1 : 32'd0);
  endfunction

  function automatic bit model_fire(input bit rw, input bit gd);
    if (m_eoc) return gd;
    if (m_blk) return rw && (m_cnt == 1);
    return m_pw && rw;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [7:0] a, input bit we,
                      input logic [31:0] wd, input bit rw, input bit gd);
    bit exp_req;
    int nxt_cnt;
    bus_addr = a; bus_we = we; bus_wdata = wd; res_wr = rw; grp_done = gd;
    exp_req = model_fire(rw, gd);
    nxt_cnt = m_cnt;
    if (we && a == 8'h4C)               nxt_cnt = int'(wd[24:16]);
    else if (m_blk && rw && m_cnt != 0) nxt_cnt = (m_cnt == 1) ? m_count : m_cnt - 1;
    @(negedge clk);
    chk(tag, 32'(dma_req), 32'(exp_req));
    m_cnt = nxt_cnt;
    if (we && a == 8'h4C) begin
      m_count = int'(wd[24:16]);
      m_eoc = wd[3]; m_blk = wd[2]; m_pw = wd[0];
    end
    chk({tag, " readback"}, bus_rdata, model_image(a));
  endtask

  task automatic wr(input string tag, input logic [31:0] wd);
    step(tag, 8'h4C, 1'b1, wd, 1'b0, 1'b0);
  endtask

  task automatic idle(input string tag, input bit rw, input bit gd);
    step(tag, 8'h4C, 1'b0, 32'h0, rw, gd);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 req", 32'(dma_req), 32'h0);
    chk("R1 reg", bus_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after", bus_rdata, 32'h0);

    // R2 reserved bits
    wr("R2", 32'hFFFF_FFFF);
    chk("R2 image", bus_rdata, 32'h01FF_000D);
    // R3 other offset
    step("R3", 8'h48, 1'b1, 32'h0, 1'b0, 1'b0);
    idle("R3", 0, 0);
    chk("R3 kept", bus_rdata, 32'h01FF_000D);

    // R4 per-result mode
    wr("R4", 32'h0000_0001);
    for (int i = 0; i < 3; i++) idle("R4", 1, 0);
    idle("R10 gd ignored", 0, 1);
    idle("R10 quiet", 0, 0);
    wr("R4", 32'h0000_0000);
    idle("R4 disabled", 1, 0);

    // R5 block mode N=3, per-result bit set but ignored
    wr("R5", 32'h0003_0005);
    for (int i = 0; i < 7; i++) idle("R5", 1, 0);

    // R6 zero count
    wr("R6", 32'h0000_0004);
    for (int i = 0; i < 5; i++) idle("R6", 1, 0);

    // R7 completion mode
    wr("R7", 32'h0000_0009);
    idle("R7 res ignored", 1, 0);
    idle("R7", 0, 1);
    idle("R7 both", 1, 1);

    // R8 completion over block
    wr("R8", 32'h0001_000C);
    idle("R8 res ignored", 1, 0);
    idle("R8", 0, 1);

    // R9 load collides with the 1->0 step
    wr("R9", 32'h0002_0004);
    idle("R9", 1, 0);
    step("R9 collide", 8'h4C, 1'b1, 32'h0005_0004, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) idle("R9", 1, 0);

    // R5 largest count
    wr("R5 max", 32'h01FF_0004);
    for (int i = 0; i < 513; i++) idle("R5 max", 1, 0);

    // Constrained random mix
    for (int i = 0; i < 5000; i++) begin
      bit we, rw, gd;
      logic [7:0]  a;
      logic [31:0] wd;
      string tag;
      we = ($urandom % 16) == 0;
      a  = (($urandom % 8) == 0) ? 8'(($urandom % 64) * 4) : 8'h4C;
      wd = $urandom;
      case ($urandom % 8)
        0:       wd[24:16] = 9'd0;
        1:       wd[24:16] = 9'd511;
        default: wd[24:16] = 9'(1 + $urandom % 5);
      endcase
      rw = $urandom % 2;
      gd = ($urandom % 8) == 0;
      if (we && a == 8'h4C && rw)  tag = "R9 rand";
      else if (m_eoc)              tag = "R7 rand";
      else if (m_blk)              tag = (m_count == 0) ? "R6 rand" : "R5 rand";
      else if (m_pw)               tag = "R4 rand";
      else                         tag = "R10 rand";
      step(tag, a, we, wd, rw, gd);
    end
    idle("R10 end", 0, 0);
    done = 1;
    report();
  end
endmodule